// File: doc/BRIEF.md
# Dual-Processor Byte Mailbox

This block joins two processors that share a board but not a bus: a host on a 16-bit bus and a disk-controller processor on an 8-bit I/O bus. Each direction has one byte of holding storage. The host posts a byte toward the controller through one of two addresses. The address it uses marks the byte as either data or a command. The controller posts a reply byte back, and one bit of the port address it writes to is kept as a reply tag.

Each side polls a few status flags to see when a byte is waiting or has been taken. Reading a data register is the event that moves the handshake forward, so no separate acknowledge strobe exists. Both bus interfaces use single-cycle read and write strobes. Read data is registered and appears on the cycle after the read strobe.

Top module: `dual_cpu_mailbox`

## Requirements
- R1: After synchronous reset, the outbound-full flag, the command tag and the reply tag are all 0, and the reply-consumed flag is 1.
- R2: A host write to word offset 0 stores `h_wbyte` as the outbound byte, sets outbound-full and clears the command tag.
- R3: A host write to word offset 8 stores `h_wbyte` as the outbound byte, sets outbound-full and sets the command tag.
- R4: A controller read at any address from 0x18 to 0x1F returns the outbound byte on `c_rdata` one cycle later and clears outbound-full.
- R5: A controller write at any address from 0x18 to 0x1F stores `c_wdata` as the reply byte, clears reply-consumed, and keeps address bit 2 of that write as the reply tag.
- R6: A host read at word offset 0 returns the reply byte, zero-extended to 16 bits, one cycle later and sets reply-consumed.
- R7: A controller read at any address from 0x00 to 0x07 returns a status byte. Bit 0 is the command tag, bit 1 is outbound-full, bit 2 is reply-consumed and bit 3 is `test_sw` (1 when the switch is open). Bits 7..4 are 0.
- R8: Host reads at word offsets 4, 5 and 6 return reply-consumed, outbound-full and the reply tag respectively in bit 0, with all other bits 0. A host read at any other offset except 0 returns 0, and a host write to any offset other than 0 and 8 has no effect.
- R9: Status reads on either side leave every flag, tag and byte unchanged.
- R10: When a host write to offset 0 or 8 and a controller data read fall in the same cycle, the controller gets the previous outbound byte and outbound-full ends set, holding the new byte.
- R11: When a controller data write and a host read of offset 0 fall in the same cycle, the host gets the previous reply byte and reply-consumed ends cleared, holding the new byte.
- R12: Controller reads at addresses outside 0x00–0x07 and 0x18–0x1F return 0, and controller writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both bus interfaces |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_addr | input | 4 | Host word offset |
| h_wbyte | input | 8 | Host write data (low byte lane) |
| h_rdata | output | 16 | Host read data, registered |
| c_wr | input | 1 | Controller write strobe, one cycle |
| c_rd | input | 1 | Controller read strobe, one cycle |
| c_addr | input | 8 | Controller I/O port address |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, registered |
| test_sw | input | 1 | Test switch level, 1 when open |

## Verification
Two pairs of functions can land in the same cycle. A host post can meet a controller take of the outbound register, and a controller reply post can meet a host take of the reply register. The bench provokes both pairs on purpose and also lets random traffic, drawn with a fixed seed, hit them by chance. Each collision is judged on two points: the read in that cycle must return the byte held before the edge, and the flag must end in the posted state, which the bench confirms with a later status read and a later data read that returns the new byte.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Host-side register selection after address decode
  typedef enum logic [2:0] {
    HS_NONE,
    HS_DATA,
    HS_CMD,
    HS_CONS,
    HS_FULL,
    HS_RTAG
  } host_sel_e;

  // Controller-side port selection after address decode
  typedef enum logic [1:0] {
    CS_NONE,
    CS_STAT,
    CS_DATA
  } ctl_sel_e;
endpackage

// File: rtl/mbox_slot.sv
// One direction of the mailbox: holding byte, pending flag, tag.
// A post and a take in the same cycle leave the slot pending.
module mbox_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post,
  input  logic          take,
  input  logic [DW-1:0] post_data,
  input  logic          post_tag,
  output logic [DW-1:0] data,
  output logic          pending,
  output logic          tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data    <= '0;
      pending <= 1'b0;
      tag     <= 1'b0;
    end else begin
      if (post) begin
        data <= post_data;
        tag  <= post_tag;
      end
      if (post)
        pending <= 1'b1;
      else if (take)
        pending <= 1'b0;
    end
  end

  // The byte only moves on a post (covers R9 for both directions)
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !post |=> $stable(data));
endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
  import mbox_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HAW      = 4,
  parameter int HDW      = 16,
  parameter int DATA_OFF = 0,
  parameter int CMD_OFF  = 8,
  parameter int STAT_OFF = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           h_wr,
  input  logic           h_rd,
  input  logic [HAW-1:0] h_addr,
  input  logic [DW-1:0]  h_wbyte,
  input  logic [DW-1:0]  rep_data,
  input  logic           rep_pending,
  input  logic           rep_tag,
  input  logic           out_pending,
  output logic           out_post,
  output logic           out_tag,
  output logic [DW-1:0]  out_data,
  output logic           rep_take,
  output logic [HDW-1:0] h_rdata
);
  host_sel_e        sel;
  logic [HDW-1:0]   rd_val;

  always_comb begin
    if (h_addr == HAW'(DATA_OFF))          sel = HS_DATA;
    else if (h_addr == HAW'(CMD_OFF))      sel = HS_CMD;
    else if (h_addr == HAW'(STAT_OFF))     sel = HS_CONS;
    else if (h_addr == HAW'(STAT_OFF + 1)) sel = HS_FULL;
    else if (h_addr == HAW'(STAT_OFF + 2)) sel = HS_RTAG;
    else                                   sel = HS_NONE;
  end

  assign out_post = h_wr && (sel == HS_DATA || sel == HS_CMD);
  assign out_tag  = (sel == HS_CMD);
  assign out_data = h_wbyte;
  assign rep_take = h_rd && (sel == HS_DATA);

  always_comb begin
    rd_val = '0;
    case (sel)
      HS_DATA: rd_val[DW-1:0] = rep_data;
      HS_CONS: rd_val[0]      = !rep_pending;
      HS_FULL: rd_val[0]      = out_pending;
      HS_RTAG: rd_val[0]      = rep_tag;
      default: rd_val         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      h_rdata <= '0;
    else if (h_rd)
      h_rdata <= rd_val;
  end

  assert_host_status_width_R8: assert property (@(posedge clk) disable iff (rst)
    h_rd && (sel == HS_CONS || sel == HS_FULL || sel == HS_RTAG)
    |=> h_rdata[HDW-1:1] == '0);

  assert_host_unmapped_read_R8: assert property (@(posedge clk) disable iff (rst)
    h_rd && (sel == HS_NONE || sel == HS_CMD) |=> h_rdata == '0);
endmodule

// File: rtl/mbox_ctl_port.sv
module mbox_ctl_port
  import mbox_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CAW     = 8,
  parameter int STAT_LO = 8'h00,
  parameter int STAT_HI = 8'h07,
  parameter int DATA_LO = 8'h18,
  parameter int DATA_HI = 8'h1F,
  parameter int TAG_BIT = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           c_wr,
  input  logic           c_rd,
  input  logic [CAW-1:0] c_addr,
  input  logic [DW-1:0]  c_wdata,
  input  logic           test_sw,
  input  logic [DW-1:0]  out_data,
  input  logic           out_pending,
  input  logic           out_tag,
  input  logic           rep_consumed,
  output logic           out_take,
  output logic           rep_post,
  output logic           rep_tag,
  output logic [DW-1:0]  rep_data,
  output logic [DW-1:0]  c_rdata
);
  ctl_sel_e      sel;
  logic [DW-1:0] stat_byte;
  logic [DW-1:0] rd_val;

  always_comb begin
    if (c_addr >= CAW'(STAT_LO) && c_addr <= CAW'(STAT_HI))      sel = CS_STAT;
    else if (c_addr >= CAW'(DATA_LO) && c_addr <= CAW'(DATA_HI)) sel = CS_DATA;
    else                                                         sel = CS_NONE;
  end

  assign out_take = c_rd && (sel == CS_DATA);
  assign rep_post = c_wr && (sel == CS_DATA);
  assign rep_tag  = c_addr[TAG_BIT];
  assign rep_data = c_wdata;

  always_comb begin
    stat_byte    = '0;
    stat_byte[0] = out_tag;
    stat_byte[1] = out_pending;
    stat_byte[2] = rep_consumed;
    stat_byte[3] = test_sw;
  end

  always_comb begin
    case (sel)
      CS_STAT: rd_val = stat_byte;
      CS_DATA: rd_val = out_data;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      c_rdata <= '0;
    else if (c_rd)
      c_rdata <= rd_val;
  end

  assert_ctl_status_upper_R7: assert property (@(posedge clk) disable iff (rst)
    c_rd && sel == CS_STAT |=> c_rdata[DW-1:4] == '0);

  assert_ctl_unmapped_read_R12: assert property (@(posedge clk) disable iff (rst)
    c_rd && sel == CS_NONE |=> c_rdata == '0);
endmodule

// File: rtl/dual_cpu_mailbox.sv
module dual_cpu_mailbox #(
  parameter int DW        = 8,
  parameter int HAW       = 4,
  parameter int HDW       = 16,
  parameter int CAW       = 8,
  parameter int H_DATA    = 0,
  parameter int H_CMD     = 8,
  parameter int H_STAT    = 4,
  parameter int C_STAT_LO = 8'h00,
  parameter int C_STAT_HI = 8'h07,
  parameter int C_DATA_LO = 8'h18,
  parameter int C_DATA_HI = 8'h1F,
  parameter int TAG_BIT   = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           h_wr,
  input  logic           h_rd,
  input  logic [HAW-1:0] h_addr,
  input  logic [DW-1:0]  h_wbyte,
  output logic [HDW-1:0] h_rdata,
  input  logic           c_wr,
  input  logic           c_rd,
  input  logic [CAW-1:0] c_addr,
  input  logic [DW-1:0]  c_wdata,
  output logic [DW-1:0]  c_rdata,
  input  logic           test_sw
);
  logic          out_post, out_take, out_tag_in, out_pending, out_tag;
  logic [DW-1:0] out_in, out_byte;
  logic          rep_post, rep_take, rep_tag_in, rep_pending, rep_tag;
  logic [DW-1:0] rep_in, rep_byte;

  mbox_host_port #(
    .DW(DW), .HAW(HAW), .HDW(HDW),
    .DATA_OFF(H_DATA), .CMD_OFF(H_CMD), .STAT_OFF(H_STAT)
  ) u_host (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wbyte(h_wbyte),
    .rep_data(rep_byte), .rep_pending(rep_pending), .rep_tag(rep_tag),
    .out_pending(out_pending),
    .out_post(out_post), .out_tag(out_tag_in), .out_data(out_in),
    .rep_take(rep_take), .h_rdata(h_rdata)
  );

  mbox_ctl_port #(
    .DW(DW), .CAW(CAW),
    .STAT_LO(C_STAT_LO), .STAT_HI(C_STAT_HI),
    .DATA_LO(C_DATA_LO), .DATA_HI(C_DATA_HI), .TAG_BIT(TAG_BIT)
  ) u_ctl (
    .clk(clk), .rst(rst),
    .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
    .test_sw(test_sw),
    .out_data(out_byte), .out_pending(out_pending), .out_tag(out_tag),
    .rep_consumed(!rep_pending),
    .out_take(out_take), .rep_post(rep_post), .rep_tag(rep_tag_in),
    .rep_data(rep_in), .c_rdata(c_rdata)
  );

  // Host -> controller
  mbox_slot #(.DW(DW)) u_outbound (
    .clk(clk), .rst(rst),
    .post(out_post), .take(out_take),
    .post_data(out_in), .post_tag(out_tag_in),
    .data(out_byte), .pending(out_pending), .tag(out_tag)
  );

  // Controller -> host; reply-consumed is the inverse of pending
  mbox_slot #(.DW(DW)) u_reply (
    .clk(clk), .rst(rst),
    .post(rep_post), .take(rep_take),
    .post_data(rep_in), .post_tag(rep_tag_in),
    .data(rep_byte), .pending(rep_pending), .tag(rep_tag)
  );

  assert_host_post_R2: assert property (@(posedge clk) disable iff (rst)
    out_post |=> out_pending && out_byte == $past(h_wbyte));

  assert_cmd_tag_R3: assert property (@(posedge clk) disable iff (rst)
    h_wr && h_addr == HAW'(H_CMD) |=> out_tag);

  assert_ctl_take_R4: assert property (@(posedge clk) disable iff (rst)
    out_take && !out_post |=> !out_pending);

  assert_reply_post_R5: assert property (@(posedge clk) disable iff (rst)
    rep_post |=> rep_pending && rep_tag == $past(c_addr[TAG_BIT]));

  assert_host_take_R6: assert property (@(posedge clk) disable iff (rst)
    rep_take && !rep_post |=> !rep_pending);

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !out_post && !out_take && !rep_post && !rep_take
    |=> $stable(out_pending) && $stable(rep_pending));

  assert_out_collide_R10: assert property (@(posedge clk) disable iff (rst)
    out_post && out_take |=> out_pending);

  assert_rep_collide_R11: assert property (@(posedge clk) disable iff (rst)
    rep_post && rep_take |=> rep_pending);
endmodule

// File: tb/test_dual_cpu_mailbox.sv
module test_dual_cpu_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr = 0, h_rd = 0;
  logic [3:0]  h_addr = 0;
  logic [7:0]  h_wbyte = 0;
  logic [15:0] h_rdata;
  logic        c_wr = 0, c_rd = 0;
  logic [7:0]  c_addr = 0, c_wdata = 0;
  logic [7:0]  c_rdata;
  logic        test_sw = 1'b1;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // Bench model of the mailbox state
  logic [7:0] m_out = 0, m_rep = 0;
  logic       m_full = 0, m_cmd = 0, m_cons = 1, m_rtag = 0;

  always #10 clk = ~clk;

  dual_cpu_mailbox i_dual_cpu_mailbox (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wbyte(h_wbyte),
    .h_rdata(h_rdata),
    .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .test_sw(test_sw)
  );

  function automatic logic [15:0] host_exp(input logic [3:0] a);
    case (a)
      4'd0: return {8'h00, m_rep};
      4'd4: return {15'd0, m_cons};
      4'd5: return {15'd0, m_full};
      4'd6: return {15'd0, m_rtag};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] ctl_exp(input logic [7:0] a);
    if (a <= 8'h07) return {4'h0, test_sw, m_cons, m_full, m_cmd};
    if (a >= 8'h18 && a <= 8'h1F) return m_out;
    return 8'h00;
  endfunction

  function automatic string host_tag(input logic [3:0] a);
    if (a == 4'd0) return "R6";
    return "R8";
  endfunction

  function automatic string ctl_tag(input logic [7:0] a);
    if (a <= 8'h07) return "R7";
    if (a >= 8'h18 && a <= 8'h1F) return "R4";
    return "R12";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle on both sides; called at a falling edge, returns at the next one
  task automatic step(input bit hw, input bit hr, input logic [3:0] ha,
                      input logic [7:0] hb, input bit cw, input bit cr,
                      input logic [7:0] ca, input logic [7:0] cd, input string tag);
    logic [15:0] eh;
    logic [7:0]  ec;
    eh = host_exp(ha);
    ec = ctl_exp(ca);
    h_wr = hw; h_rd = hr; h_addr = ha; h_wbyte = hb;
    c_wr = cw; c_rd = cr; c_addr = ca; c_wdata = cd;
    @(negedge clk);
    if (hr) check(h_rdata == eh, (tag != "") ? tag : host_tag(ha), "host read", h_rdata, eh);
    if (cr) check(c_rdata == ec, (tag != "") ? tag : ctl_tag(ca), "ctl read", {8'h00, c_rdata}, {8'h00, ec});
    // model update: take first, then post, so a post wins
    if (cr && ca >= 8'h18 && ca <= 8'h1F) m_full = 1'b0;
    if (hw && (ha == 4'd0 || ha == 4'd8)) begin
      m_out = hb; m_full = 1'b1; m_cmd = (ha == 4'd8);
    end
    if (hr && ha == 4'd0) m_cons = 1'b1;
    if (cw && ca >= 8'h18 && ca <= 8'h1F) begin
      m_rep = cd; m_cons = 1'b0; m_rtag = ca[2];
    end
  endtask

  task automatic idle();
    step(0, 0, 4'd15, 8'h00, 0, 0, 8'hFF, 8'h00, "");
  endtask

  task automatic h_read(input logic [3:0] a, input string tag);
    step(0, 1, a, 8'h00, 0, 0, 8'hFF, 8'h00, tag);
  endtask

  task automatic c_read(input logic [7:0] a, input string tag);
    step(0, 0, 4'd15, 8'h00, 0, 1, a, 8'h00, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    c_read(8'h00, "R1");
    h_read(4'd4, "R1");
    h_read(4'd5, "R1");
    h_read(4'd6, "R1");

    // R2: data post
    step(1, 0, 4'd0, 8'hA5, 0, 0, 8'hFF, 8'h00, "R2");
    c_read(8'h03, "R2");
    h_read(4'd5, "R2");
    // R3: command post overwrites and tags
    step(1, 0, 4'd8, 8'h3C, 0, 0, 8'hFF, 8'h00, "R3");
    c_read(8'h05, "R3");
    // R4: controller take
    c_read(8'h1A, "R4");
    c_read(8'h07, "R4");
    h_read(4'd5, "R4");
    // R9: repeated status reads change nothing
    c_read(8'h00, "R9");
    c_read(8'h02, "R9");
    h_read(4'd4, "R9");
    h_read(4'd4, "R9");
    h_read(4'd6, "R9");
    // R5: reply posts with both tag values
    step(0, 0, 4'd15, 8'h00, 1, 0, 8'h1C, 8'h5A, "R5");
    h_read(4'd6, "R5");
    h_read(4'd4, "R5");
    step(0, 0, 4'd15, 8'h00, 1, 0, 8'h18, 8'h11, "R5");
    h_read(4'd6, "R5");
    // R6: host take
    h_read(4'd0, "R6");
    h_read(4'd4, "R6");
    c_read(8'h04, "R6");
    // R10: post meets take
    step(1, 0, 4'd0, 8'h42, 0, 0, 8'hFF, 8'h00, "R10");
    c_read(8'h1B, "R10");
    step(1, 0, 4'd0, 8'h77, 0, 1, 8'h1E, 8'h00, "R10");
    c_read(8'h01, "R10");
    c_read(8'h19, "R10");
    h_read(4'd5, "R10");
    // R11: reply post meets host take
    step(0, 0, 4'd15, 8'h00, 1, 0, 8'h1D, 8'h2B, "R11");
    step(0, 1, 4'd0, 8'h00, 1, 0, 8'h1F, 8'h99, "R11");
    h_read(4'd4, "R11");
    h_read(4'd0, "R11");
    // R12: unmapped controller addresses
    step(0, 0, 4'd15, 8'h00, 1, 0, 8'h20, 8'hEE, "R12");
    step(0, 0, 4'd15, 8'h00, 1, 0, 8'h17, 8'hEE, "R12");
    h_read(4'd4, "R12");
    c_read(8'h08, "R12");
    c_read(8'h40, "R12");
    c_read(8'hFF, "R12");
    // R8: ignored host writes and unmapped host reads
    step(1, 0, 4'd3, 8'hCC, 0, 0, 8'hFF, 8'h00, "R8");
    step(1, 0, 4'd5, 8'hCC, 0, 0, 8'hFF, 8'h00, "R8");
    c_read(8'h00, "R8");
    h_read(4'd8, "R8");
    h_read(4'd3, "R8");
    // R7: test switch closed
    test_sw = 1'b0;
    c_read(8'h06, "R7");
    test_sw = 1'b1;
    c_read(8'h06, "R7");

    // Random interleaved traffic from both processors
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] ha;
      logic [7:0] ca;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: ha = 4'd0;
        1: ha = 4'd8;
        2: ha = 4'd4;
        3: ha = 4'd5;
        4: ha = 4'd6;
        default: ha = 4'($urandom_range(0, 15));
      endcase
      pick = $urandom_range(0, 4);
      case (pick)
        0, 1: ca = 8'($urandom_range(8'h18, 8'h1F));
        2, 3: ca = 8'($urandom_range(0, 7));
        default: ca = 8'($urandom_range(0, 255));
      endcase
      test_sw = 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ha, 8'($urandom),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ca, 8'($urandom), "");
    end

    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule